// File: doc/BRIEF.md
# USB boot reset sequencer

This block brings up the USB PHYs, device controllers and hosts once after system reset, in a fixed order. A single `start` pulse launches it. The sequencer first places every selected device controller, every host and every PHY into reset. It then drops the run/select (RS) control bit of each PHY and lets the PHYs out of reset while devices and hosts stay held. After a settling interval of a set number of clock cycles, it raises RS again and finally releases the devices and hosts. `done` then reports completion.

Which device controllers take part is decided by a 32-bit module-disable word that is sampled in the cycle `start` is accepted. A device whose gating bit is set is never driven by the sequencer; its reset line simply follows a caller-held level on `devHeld`. The `THREE_PHY` parameter picks between a two-PHY/one-host build and a three-PHY/two-host build. `WAIT_CYCLES` sets the settling interval; the default of 6250 gives 50 µs at 125 MHz. In the two-PHY build the gating bits are 9 (device 0), 8 (device 1), 21 (devices 2–4) and 22 (devices 5–9).

Top module: `usb_boot_rst_seq`

## Requirements
- R1: After system reset, `devRst` equals `devHeld`, `hostRst` and `phyRst` are all zero, `phyRs` is all ones and `done` is low.
- R2: One cycle after the edge that accepts `start`, all selected device resets, all host resets and all PHY resets are asserted together.
- R3: In the three-PHY build, devices 0–3 are selected when module-disable bit 9 is clear, devices 4–7 when bit 22 is clear, device 8 when bit 24 is clear and device 9 when bit 21 is clear. The word is sampled only at the edge that accepts `start`.
- R4: A device that is not selected has `devRst` equal to its `devHeld` bit throughout the sequence. A device that is selected sees `devHeld` ORed onto its reset.
- R5: The cycle after the assertion step, all `phyRs` bits go low. The cycle after that, all `phyRst` bits go low while device and host resets stay asserted.
- R6: `phyRs` returns to all ones exactly `WAIT_CYCLES` + 1 cycles after the PHY resets are released. This is 4 + `WAIT_CYCLES` edges after the accepting edge.
- R7: One cycle after RS is set, every device and host reset asserted by the sequence is released, and `done` rises in the same cycle.
- R8: `done` stays high until `start` is seen again. A `start` seen while done restarts the sequence and drops `done` at the next edge.
- R9: `start` has no effect while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| start | input | 1 | Launches the sequence when idle or done |
| modDisable | input | 32 | Module-disable word; a set gating bit excludes its devices |
| devHeld | input | 10 | Reset levels held by other logic, ORed onto device resets |
| devRst | output | 10 | Device controller reset lines, active high |
| hostRst | output | NHOST (2) | Host reset lines, active high |
| phyRst | output | NPHY (3) | PHY reset lines, active high |
| phyRs | output | NPHY (3) | PHY run/select control bits |
| done | output | 1 | Sequence complete |

## Verification
The sequence is first run with the module-disable word clear, so all ten devices are selected. Next, only the devices 0–3 group is disabled and `devHeld` changes in the middle of the run; this shows that excluded devices follow `devHeld` and are not touched by the sequencer. The sequence is then run with the other three gating bits set and `start` held high across completion, which checks restart-from-done and the per-bit group mapping. A final run with every bit set shows that hosts and PHYs are still sequenced when no device is selected. Changing the module-disable word and pulsing `start` in the middle of a run separates a correct sample-at-start design from one that follows the live word or restarts on a late pulse.

// File: rtl/usb_boot_rst_pkg.sv
package usb_boot_rst_pkg;

  localparam int unsigned NUM_DEV = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ASSERT, ST_RSCLR, ST_PHYREL, ST_WAIT, ST_RSSET, ST_RELEASE, ST_DONE
  } seqState_t;

  // Strobes from control to datapath, one per sequence step
  typedef struct packed {
    logic latchSel;
    logic assertAll;
    logic clrRs;
    logic relPhy;
    logic setRs;
    logic relDev;
  } seqStrobe_t;

  // Module-disable bit that gates device 'dev' for the chosen variant
  function automatic int unsigned gateBit(input int unsigned dev, input bit threePhy);
    if (threePhy) begin
      if (dev < 4)       return 9;
      else if (dev < 8)  return 22;
      else if (dev == 8) return 24;
      else               return 21;
    end else begin
      if (dev == 0)      return 9;
      else if (dev == 1) return 8;
      else if (dev < 5)  return 21;
      else               return 22;
    end
  endfunction

endpackage

// File: rtl/usb_boot_rst_ctrl.sv
module usb_boot_rst_ctrl
  import usb_boot_rst_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 6250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t strb,
  output logic       done
);
  localparam int unsigned CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAIT_CYCLES - 1);

  seqState_t state, stateNext;
  logic [CW-1:0] waitCnt;
  logic loadCnt;

  always_comb begin
    stateNext = state;
    strb      = '0;
    loadCnt   = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: if (start) begin
        stateNext     = ST_ASSERT;
        strb.latchSel = 1'b1;
      end
      ST_ASSERT: begin
        strb.assertAll = 1'b1;
        stateNext      = ST_RSCLR;
      end
      ST_RSCLR: begin
        strb.clrRs = 1'b1;
        stateNext  = ST_PHYREL;
      end
      ST_PHYREL: begin
        strb.relPhy = 1'b1;
        loadCnt     = 1'b1;
        stateNext   = ST_WAIT;
      end
      ST_WAIT: if (waitCnt == '0) stateNext = ST_RSSET;
      ST_RSSET: begin
        strb.setRs = 1'b1;
        stateNext  = ST_RELEASE;
      end
      ST_RELEASE: begin
        strb.relDev = 1'b1;
        stateNext   = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (loadCnt)
        waitCnt <= CNT_LOAD;
      else if (state == ST_WAIT && waitCnt != '0)
        waitCnt <= waitCnt - 1'b1;
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/usb_boot_rst_dp.sv
module usb_boot_rst_dp
  import usb_boot_rst_pkg::*;
#(
  parameter bit          THREE_PHY = 1'b1,
  parameter int unsigned NHOST     = 2,
  parameter int unsigned NPHY      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [31:0]        modDisable,
  input  logic [NUM_DEV-1:0] devHeld,
  output logic [NUM_DEV-1:0] devRst,
  output logic [NHOST-1:0]   hostRst,
  output logic [NPHY-1:0]    phyRst,
  output logic [NPHY-1:0]    phyRs
);
  logic [NUM_DEV-1:0] selNow, selQ, devSeq;
  logic [NHOST-1:0]   hostSeq;
  logic [NPHY-1:0]    phyRstQ, phyRsQ;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
    localparam int unsigned GBIT = gateBit(i, THREE_PHY);
    assign selNow[i] = ~modDisable[GBIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= '0;
      devSeq  <= '0;
      hostSeq <= '0;
      phyRstQ <= '0;
      phyRsQ  <= '1;
    end else begin
      if (strb.latchSel) selQ <= selNow;
      if (strb.assertAll) begin
        devSeq  <= selQ;
        hostSeq <= '1;
        phyRstQ <= '1;
      end
      if (strb.clrRs)  phyRsQ  <= '0;
      if (strb.relPhy) phyRstQ <= '0;
      if (strb.setRs)  phyRsQ  <= '1;
      if (strb.relDev) begin
        devSeq  <= '0;
        hostSeq <= '0;
      end
    end
  end

  assign devRst  = devSeq | devHeld;
  assign hostRst = hostSeq;
  assign phyRst  = phyRstQ;
  assign phyRs   = phyRsQ;

endmodule

// File: rtl/usb_boot_rst_seq.sv
module usb_boot_rst_seq
  import usb_boot_rst_pkg::*;
#(
  parameter bit          THREE_PHY   = 1'b1,
  parameter int unsigned WAIT_CYCLES = 6250,
  localparam int unsigned NHOST = THREE_PHY ? 2 : 1,
  localparam int unsigned NPHY  = THREE_PHY ? 3 : 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [31:0]        modDisable,
  input  logic [NUM_DEV-1:0] devHeld,
  output logic [NUM_DEV-1:0] devRst,
  output logic [NHOST-1:0]   hostRst,
  output logic [NPHY-1:0]    phyRst,
  output logic [NPHY-1:0]    phyRs,
  output logic               done
);
  seqStrobe_t strb;

  usb_boot_rst_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb), .done(done)
  );

  usb_boot_rst_dp #(.THREE_PHY(THREE_PHY), .NHOST(NHOST), .NPHY(NPHY)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .modDisable(modDisable),
    .devHeld(devHeld), .devRst(devRst), .hostRst(hostRst),
    .phyRst(phyRst), .phyRs(phyRs)
  );

endmodule

// File: rtl/usb_boot_rst_chk.sv
module usb_boot_rst_chk #(
  parameter int unsigned NHOST = 2,
  parameter int unsigned NPHY  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic [NHOST-1:0] hostRst,
  input logic [NPHY-1:0]  phyRst,
  input logic [NPHY-1:0]  phyRs
);
  // R2
  assert_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostRst[0]) |-> ((&phyRst) && (&hostRst)));

  // R5
  rs_low_at_phy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyRst[0]) |-> ((phyRs == '0) && hostRst[0]));

  // R6
  rs_set_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyRs[0]) |-> ((phyRst == '0) && hostRst[0]));

  // R7
  release_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostRst[0]) |-> ((&phyRs) && done && (hostRst == '0)));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

bind usb_boot_rst_seq usb_boot_rst_chk #(.NHOST(NHOST), .NPHY(NPHY)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .hostRst(hostRst), .phyRst(phyRst), .phyRs(phyRs)
);

// File: tb/usb_boot_rst_seq_tb_top.sv
module usb_boot_rst_seq_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] modDisable = '0;
  logic [9:0]  devHeld = '0;
  logic [9:0]  devRst;
  logic [1:0]  hostRst;
  logic [2:0]  phyRst, phyRs;
  logic        done;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  usb_boot_rst_seq #(.THREE_PHY(1'b1), .WAIT_CYCLES(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modDisable(modDisable),
    .devHeld(devHeld), .devRst(devRst), .hostRst(hostRst),
    .phyRst(phyRst), .phyRs(phyRs), .done(done)
  );

  // Reference model: t counts edges since start was accepted (-1 = never)
  int t = -1;
  bit doneM = 0;
  logic [9:0] selM = '0;

  function automatic logic [9:0] refSel(input logic [31:0] md);
    logic [9:0] s;
    s[3:0] = {4{~md[9]}};
    s[7:4] = {4{~md[22]}};
    s[8]   = ~md[24];
    s[9]   = ~md[21];
    return s;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      t = -1; doneM = 0; selM = '0;
    end else if ((t < 0 || doneM) && start) begin
      t = 0; doneM = 0; selM = refSel(modDisable);
    end else if (t >= 0 && !doneM) begin
      t++;
      if (t == 5 + W) doneM = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", tag, act, exp, t);
    end
  endtask

  // Compare every cycle, away from the clock edge
  always @(negedge clk) if (rstN && !finished) begin
    bit busy;
    logic [9:0] eDev;
    busy = (t >= 1) && (t < 5 + W);
    eDev = devHeld | (busy ? selM : 10'h0);
    chk(devRst == eDev, "R3/R4 devRst", 32'(devRst), 32'(eDev));
    chk(hostRst == (busy ? 2'b11 : 2'b00), "R2 hostRst", 32'(hostRst), busy ? 32'h3 : 32'h0);
    chk(phyRst == ((t >= 1 && t < 3) ? 3'b111 : 3'b000), "R5 phyRst", 32'(phyRst),
        (t >= 1 && t < 3) ? 32'h7 : 32'h0);
    chk(phyRs == ((t >= 2 && t < 4 + W) ? 3'b000 : 3'b111), "R6 phyRs", 32'(phyRs),
        (t >= 2 && t < 4 + W) ? 32'h0 : 32'h7);
    chk(done == doneM, "R7 done", 32'(done), 32'(doneM));
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse();
    start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    devHeld = 10'h001;
    step(3);
    #2;
    // R1: reset state
    chk(devRst == 10'h001 && hostRst == 0 && phyRst == 0 && phyRs == 3'b111 && !done,
        "R1 reset state", {devRst, hostRst, phyRst, phyRs, done}, {10'h001, 2'b0, 3'b0, 3'b111, 1'b0});
    rstN = 1'b1;
    devHeld = '0;
    step(2);

    // Run 1: every device enabled
    pulse();
    step(W + 8);

    // Run 2: devices 0-3 disabled, held pattern changes mid-run
    modDisable = 32'h0000_0200;
    devHeld = 10'h005;
    pulse();
    step(4);
    modDisable = '0;          // R3: sampled only at start
    start = 1'b1;             // R9: ignored while running
    step(1);
    start = 1'b0;
    @(negedge clk);
    chk(devRst[3:0] == 4'b0101, "R4 disabled devices follow held", 32'(devRst[3:0]), 32'h5);
    #2;
    devHeld = 10'h00A;
    @(negedge clk);
    chk(devRst[3:0] == 4'b1010, "R4 held change passes through", 32'(devRst[3:0]), 32'hA);
    #2;
    step(W + 6);
    devHeld = '0;
    step(5);
    @(negedge clk);
    chk(done == 1'b1, "R8 done holds", 32'(done), 32'h1);
    #2;

    // Run 3: groups 4-7, 8, 9 disabled; start held across completion (R8 restart)
    modDisable = (32'h1 << 21) | (32'h1 << 22) | (32'h1 << 24);
    start = 1'b1;
    step(2 * W + 14);
    start = 1'b0;
    step(W + 8);

    // Run 4: every device disabled; hosts and PHYs still sequenced
    modDisable = '1;
    pulse();
    step(W + 8);
    @(negedge clk);
    chk(done == 1'b1 && hostRst == 0, "R7 complete with no devices", {done, hostRst}, 32'h4);
    summary();
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule